// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block drives the raster timing of an LCD panel. It runs two cascaded position counters, one for pixels within a line and one for lines within a frame. It decodes each counter against programmable thresholds to produce a horizontal sync, a vertical sync and a display-enable strobe. Every threshold is a plain register-width input. On each axis the sync pulse comes first, starting at position zero. The back porch, the active window and the front porch follow it in turn, and the axis wraps at its programmed total.

The current line number is brought out for software, which uses it to tell whether the frame is in its sync or blanking part. A compare register names one line. When the raster reaches the first pixel of that line, a sticky interrupt flag is set, and software clears it with a write-one-to-clear pulse. A two-bit polarity input sets the active level of each sync output. The usual value is 3, which makes both syncs active high.

Top module: `lcd_timing_gen`

## Requirements
- R1: The pixel counter `h_pos_o` is 0 after reset and advances by one each clock. When `h_pos_o + 1 >= h_total_i`, the next value is 0 instead. With a total of 0 or 1 the counter stays at 0.
- R2: The line counter `line_o` is 0 after reset and changes only on a clock where the pixel counter wraps. On that clock it advances by one, except that it goes to 0 when `line_o + 1 >= v_total_i`.
- R3: The horizontal sync region is active exactly while `h_pos_o < h_sync_end_i`. The vertical sync region is active exactly while `line_o < v_sync_end_i`. A sync end of 0 gives no sync region.
- R4: Polarity bit 0 controls `hsync_o` and bit 1 controls `vsync_o`. When the bit is 1, the output is 1 inside the sync region and 0 outside it. When the bit is 0, the output is inverted.
- R5: `de_o` is 1 exactly when both of these hold: `h_disp_start_i <= h_pos_o < h_disp_start_i + h_active_i`, and `v_disp_start_i <= line_o < v_disp_start_i + v_active_i`. The sums are formed without overflow.
- R6: The interrupt flag `irq_o` becomes 1 on the clock after a cycle in which `h_pos_o == 0` and `line_o == match_line_i`. It then stays 1 until it is cleared.
- R7: A 1 on `irq_clr_i` clears `irq_o` at the next clock. If a new match occurs in the same cycle as the clear, the flag stays set.
- R8: While `rst_ni` is low, both counters are 0 and `irq_o` is 0. The sync outputs and `de_o` follow from the counters and the programmed values as stated in R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_sync_end_i | input | 16 | Pixel position where horizontal sync ends (sync length) |
| h_disp_start_i | input | 16 | First active pixel position |
| h_active_i | input | 16 | Active pixels per line |
| h_total_i | input | 16 | Pixels per line including blanking |
| v_sync_end_i | input | 16 | Line where vertical sync ends (sync length) |
| v_disp_start_i | input | 16 | First active line |
| v_active_i | input | 16 | Active lines per frame |
| v_total_i | input | 16 | Lines per frame including blanking |
| match_line_i | input | 16 | Line that raises the interrupt |
| sync_pol_i | input | 2 | Sync polarity: bit 0 horizontal, bit 1 vertical, 1 means active high |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| h_pos_o | output | 16 | Current pixel position in the line |
| line_o | output | 16 | Current line number |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| irq_o | output | 1 | Sticky line-match interrupt flag |

## Verification
A wrong wrap point on either counter shows at `h_pos_o` or `line_o` on the first wrap, which is at most one line or one frame after reset. From that point every later position differs from the arithmetic model. A decode error in a sync or enable window shows the first time the raster crosses that threshold. An error in the interrupt logic shows on the clock after the first pass of the raster over the match line, or on the clock after a clear pulse. Each fault therefore appears within one frame of the small configurations that are swept. Those configurations include a total of one and active windows that run to the end of the line.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  typedef enum int unsigned {
    AXIS_H = 0,
    AXIS_V = 1
  } axis_e;

  localparam int unsigned NUM_AXES = 2;
endpackage

// File: rtl/lcd_axis_counter.sv
module lcd_axis_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] total_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;
  logic             at_end;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  // Wrap also recovers when total is lowered below the current count.
  assign at_end  = cnt_inc >= {1'b0, total_i};
  assign wrap_o  = step_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (at_end) cnt_q <= '0;
      else        cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lcd_axis_decode.sv
module lcd_axis_decode #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] sync_end_i,
  input  logic [CNT_W-1:0] disp_start_i,
  input  logic [CNT_W-1:0] active_i,
  output logic             sync_o,
  output logic             active_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] disp_end;
  logic             past_start;
  logic             before_end;

  assign disp_end   = {1'b0, disp_start_i} + {1'b0, active_i};
  assign past_start = cnt_i >= disp_start_i;
  assign before_end = {1'b0, cnt_i} < disp_end;

  assign sync_o   = cnt_i < sync_end_i;
  assign active_o = past_start & before_end;
endmodule

// File: rtl/lcd_line_irq.sv
module lcd_line_irq #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] h_cnt_i,
  input  logic [CNT_W-1:0] line_i,
  input  logic [CNT_W-1:0] match_line_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic hit;
  logic irq_q;

  assign hit = (h_cnt_i == '0) && (line_i == match_line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (hit)   irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned POL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] h_sync_end_i,
  input  logic [CNT_W-1:0] h_disp_start_i,
  input  logic [CNT_W-1:0] h_active_i,
  input  logic [CNT_W-1:0] h_total_i,
  input  logic [CNT_W-1:0] v_sync_end_i,
  input  logic [CNT_W-1:0] v_disp_start_i,
  input  logic [CNT_W-1:0] v_active_i,
  input  logic [CNT_W-1:0] v_total_i,
  input  logic [CNT_W-1:0] match_line_i,
  input  logic [POL_W-1:0] sync_pol_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] h_pos_o,
  output logic [CNT_W-1:0] line_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] total_a      [NUM_AXES];
  logic [CNT_W-1:0] sync_end_a   [NUM_AXES];
  logic [CNT_W-1:0] disp_start_a [NUM_AXES];
  logic [CNT_W-1:0] active_a     [NUM_AXES];
  logic [CNT_W-1:0] cnt_a        [NUM_AXES];
  logic [NUM_AXES-1:0] step_a;
  logic [NUM_AXES-1:0] wrap_a;
  logic [NUM_AXES-1:0] sync_a;
  logic [NUM_AXES-1:0] act_a;
  logic [CNT_W-1:0] h_cnt;

  assign total_a[AXIS_H]      = h_total_i;
  assign total_a[AXIS_V]      = v_total_i;
  assign sync_end_a[AXIS_H]   = h_sync_end_i;
  assign sync_end_a[AXIS_V]   = v_sync_end_i;
  assign disp_start_a[AXIS_H] = h_disp_start_i;
  assign disp_start_a[AXIS_V] = v_disp_start_i;
  assign active_a[AXIS_H]     = h_active_i;
  assign active_a[AXIS_V]     = v_active_i;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    if (a == AXIS_H) begin : g_step_free
      assign step_a[a] = 1'b1;
    end else begin : g_step_cascade
      assign step_a[a] = wrap_a[a-1];
    end

    lcd_axis_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step_a[a]),
      .total_i (total_a[a]),
      .cnt_o   (cnt_a[a]),
      .wrap_o  (wrap_a[a])
    );

    lcd_axis_decode #(.CNT_W(CNT_W)) u_dec (
      .cnt_i        (cnt_a[a]),
      .sync_end_i   (sync_end_a[a]),
      .disp_start_i (disp_start_a[a]),
      .active_i     (active_a[a]),
      .sync_o       (sync_a[a]),
      .active_o     (act_a[a])
    );
  end

  assign h_cnt = cnt_a[AXIS_H];

  lcd_line_irq #(.CNT_W(CNT_W)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .h_cnt_i      (h_cnt),
    .line_i       (cnt_a[AXIS_V]),
    .match_line_i (match_line_i),
    .clr_i        (irq_clr_i),
    .irq_o        (irq_o)
  );

  // Polarity bit 1 drives the active level high.
  assign hsync_o = ~(sync_a[AXIS_H] ^ sync_pol_i[AXIS_H]);
  assign vsync_o = ~(sync_a[AXIS_V] ^ sync_pol_i[AXIS_V]);
  assign de_o    = &act_a;
  assign h_pos_o = h_cnt;
  assign line_o  = cnt_a[AXIS_V];
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] h_total_i,
  input logic [CNT_W-1:0] v_total_i,
  input logic [CNT_W-1:0] match_line_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] h_pos_o,
  input logic [CNT_W-1:0] line_o,
  input logic             irq_o
);
  p_h_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_pos_o != '0) |-> (h_pos_o == $past(h_pos_o) + CNT_W'(1)));

  p_h_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, h_pos_o} + 17'd1 >= {1'b0, h_total_i}) && $stable(h_total_i) |=> (h_pos_o == '0));

  p_line_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_pos_o != '0) |-> $stable(line_o));

  p_line_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> ((line_o == '0) || (line_o == $past(line_o) + CNT_W'(1))));

  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_pos_o == '0) && (line_o == match_line_i) |=> irq_o);

  p_irq_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !((h_pos_o == '0) && (line_o == match_line_i)) |=> !irq_o);

  p_v_total_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_total_i > CNT_W'(1)) && $stable(v_total_i) && (line_o != '0) |-> (line_o < v_total_i));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .h_total_i    (h_total_i),
  .v_total_i    (v_total_i),
  .match_line_i (match_line_i),
  .irq_clr_i    (irq_clr_i),
  .h_pos_o      (h_pos_o),
  .line_o       (line_o),
  .irq_o        (irq_o)
);

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hse, hds, hact, ht, vse, vds, vact, vt, mline;
  logic [1:0]  pol;
  logic        clr = 1'b0;
  logic [15:0] h_pos, line;
  logic        hs, vs, de, irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_timing_gen u_lcd_timing_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .h_sync_end_i(hse), .h_disp_start_i(hds), .h_active_i(hact), .h_total_i(ht),
    .v_sync_end_i(vse), .v_disp_start_i(vds), .v_active_i(vact), .v_total_i(vt),
    .match_line_i(mline), .sync_pol_i(pol), .irq_clr_i(clr),
    .h_pos_o(h_pos), .line_o(line), .hsync_o(hs), .vsync_o(vs), .de_o(de), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int wrap_len(input int t);
    return (t < 1) ? 1 : t;
  endfunction

  task automatic run_cfg(input int c_ht, input int c_hse, input int c_hds, input int c_hact,
                         input int c_vt, input int c_vse, input int c_vds, input int c_vact,
                         input int c_m, input int c_pol, input int frames);
    int  hl, vl, eh, ev, steps;
    bit  ex_irq, sy, ac;
    ht = 16'(c_ht); hse = 16'(c_hse); hds = 16'(c_hds); hact = 16'(c_hact);
    vt = 16'(c_vt); vse = 16'(c_vse); vds = 16'(c_vds); vact = 16'(c_vact);
    mline = 16'(c_m); pol = 2'(c_pol); clr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk("R8 h_pos in reset", int'(h_pos), 0);
    chk("R8 line in reset", int'(line), 0);
    chk("R8 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    hl = wrap_len(c_ht);
    vl = wrap_len(c_vt);
    steps = hl * vl * frames;
    ex_irq = 1'b0;
    for (int n = 0; n < steps; n++) begin
      eh = n % hl;
      ev = (n / hl) % vl;
      chk("R1 h_pos", int'(h_pos), eh);
      chk("R2 line", int'(line), ev);
      sy = eh < c_hse;
      chk("R3/R4 hsync", int'(hs), int'(c_pol[0] ? sy : !sy));
      sy = ev < c_vse;
      chk("R3/R4 vsync", int'(vs), int'(c_pol[1] ? sy : !sy));
      ac = (eh >= c_hds) && (eh < c_hds + c_hact) && (ev >= c_vds) && (ev < c_vds + c_vact);
      chk("R5 de", int'(de), int'(ac));
      chk("R6/R7 irq", int'(irq), int'(ex_irq));
      clr = ((n % 13) == 7) || ((eh == 0) && (ev == c_m) && (n % 2 == 0));
      ex_irq = ((eh == 0) && (ev == c_m)) || (ex_irq && !clr);
      @(negedge clk);
    end
    clr = 1'b0;
  endtask

  initial begin
    hse = 0; hds = 0; hact = 0; ht = 0; vse = 0; vds = 0; vact = 0; vt = 0; mline = 0; pol = 0;
    @(negedge clk);
    run_cfg(10, 2, 3, 5, 6, 1, 2, 3, 4, 3, 3);
    run_cfg(7, 1, 1, 6, 5, 2, 2, 2, 0, 0, 3);
    run_cfg(1, 0, 0, 1, 4, 1, 1, 2, 3, 1, 4);
    run_cfg(0, 1, 0, 1, 3, 0, 0, 3, 2, 2, 4);
    run_cfg(12, 3, 4, 8, 7, 2, 3, 4, 9, 3, 2);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule